// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block keeps track of the processor's power state. It also decides which oscillators run and which clock drives the CPU.

There are two running states:
- **Green**: slow sub clock only.
- **Normal**: main oscillator on, CPU clocked from it.

There are two halted states:
- **Idle**: CPU stopped, sub clock kept running.
- **Sleep**: both oscillators stopped.

Software moves between the states with three controls: a sleep-instruction strobe, an idle/sleep choice bit and a fast-clock select bit. An external wake-up event ends a halt.

Every wake-up returns the CPU to Green, after a delay counted in sub-clock ticks. From Idle the delay is a short fixed count. From Sleep the controller does three things in turn:
1. It re-enables the sub oscillator and waits for a ready indication.
2. It counts a long settling interval, a parameter standing in for roughly 18 ms of sub-clock ticks.
3. It counts the same short interval used for Idle.

Going from Green to Normal turns the main oscillator on first. The CPU stays on the sub clock until the main oscillator reports that it is stable. A boot option bit picks whether reset lands in Green or in Normal.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low (synchronous, sampled on the rising edge), the controller enters Green when `boot_fast` is 0 and Normal when `boot_fast` is 1.
- R2: The outputs `{main_osc_en, sub_osc_en, cpu_clk_en, cpu_clk_main, mode_code}` take these values in each state:

  | State | Outputs | `mode_code` |
  |---|---|---|
  | Green | `0,1,1,0` | `2'b00` |
  | Normal | `1,1,1,1` | `2'b01` |
  | Idle | `0,1,0,0` | `2'b10` |
  | Sleep | `0,0,0,0` | `2'b11` |

- R3: A `sleep_req` pulse seen while the CPU clock is enabled moves the controller, one edge later, to Idle if `idle_sel` is 1 and to Sleep if it is 0.
- R4: In Green, `clk_fast_sel`=1 raises `main_osc_en` one edge later. The outputs then read `1,1,1,0` with code Green, and stay so while `main_stable` is 0. The first edge with `main_stable`=1 enters Normal.
- R5: `clk_fast_sel`=0 in Normal, or while a switch to Normal is pending, returns the controller to Green one edge later, with the main oscillator off.
- R6: A `wake_evt` in Idle starts the short delay. During it the outputs stay at the Idle pattern. Green is entered on the edge of the `SHORT_TICKS`-th `sub_tick` pulse (16 by default).
- R7: A `wake_evt` in Sleep raises `sub_osc_en` one edge later, with the CPU clock still off and code Sleep (`0,1,0,0`/`2'b11`).
  - Ticks are not counted until an edge with `sub_ready`=1 starts the long delay.
  - The long delay ends on the edge of the `LONG_TICKS`-th tick.
  - The short delay follows with the Idle pattern. It ends in Green on its `SHORT_TICKS`-th tick.
- R8: During any wake-up delay, `sleep_req` and `clk_fast_sel` have no effect, and no tick carries over between delay phases.
- R9: In a running state, `wake_evt` and `sub_tick` have no effect. In Idle or Sleep without a wake event, ticks have no effect.
- R10: When `sleep_req` and `clk_fast_sel` are both 1 in Green, the sleep request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_fast | input | 1 | Reset target option: 0 Green, 1 Normal |
| sleep_req | input | 1 | One-cycle strobe from the sleep instruction |
| idle_sel | input | 1 | Halt choice: 1 Idle, 0 Sleep |
| clk_fast_sel | input | 1 | CPU clock request: 1 main clock, 0 sub clock |
| wake_evt | input | 1 | Wake-up event |
| sub_tick | input | 1 | One-cycle pulse per sub-clock period |
| sub_ready | input | 1 | Sub oscillator has finished starting up |
| main_stable | input | 1 | Main oscillator output is stable |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_clk_main | output | 1 | CPU clock source: 1 main, 0 sub |
| mode_code | output | 2 | Current mode: 00 Green, 01 Normal, 10 Idle, 11 Sleep |

## Verification
The state transitions are driven with each control on its own and then with controls in conflict:
- Sleep with `clk_fast_sel` set separates the priority order from the plain transitions.
- Holding `main_stable` low for several cycles separates a correct wait for stability from a switch taken too early.

Wake-up is stepped one tick at a time, with the outputs checked one tick before and on the final tick. This distinguishes an exact count from one that is off by one, and tells which phase of the sleep wake-up sequence is active. Stray ticks, wake events and sleep strobes are then issued where they must be ignored: ticks before the sub oscillator is ready, mid-delay sleep requests, and wakes while running. Each is followed by a check that no delay advanced early.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_GREEN  = 3'd0,
    ST_SWITCH = 3'd1,
    ST_NORMAL = 3'd2,
    ST_IDLE   = 3'd3,
    ST_SLEEP  = 3'd4,
    ST_SETUP  = 3'd5,
    ST_LONG   = 3'd6,
    ST_SHORT  = 3'd7
  } pm_state_e;

  typedef enum logic [1:0] {
    MODE_GREEN  = 2'b00,
    MODE_NORMAL = 2'b01,
    MODE_IDLE   = 2'b10,
    MODE_SLEEP  = 2'b11
  } pm_mode_e;

  typedef struct packed {
    logic     main_on;
    logic     sub_on;
    logic     cpu_on;
    logic     cpu_fast;
    pm_mode_e mode;
  } pm_out_t;

  // width able to hold the larger of two tick limits
  function automatic int cnt_width(int a, int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // true when one more tick completes a delay of 'limit' ticks
  function automatic logic last_tick(int unsigned cnt, int unsigned limit);
    return (cnt + 1) == limit;
  endfunction

  function automatic pm_state_e halt_target(logic to_idle);
    return to_idle ? ST_IDLE : ST_SLEEP;
  endfunction

  function automatic logic is_running(pm_state_e s);
    return (s == ST_GREEN) || (s == ST_SWITCH) || (s == ST_NORMAL);
  endfunction

  function automatic logic is_counting(pm_state_e s);
    return (s == ST_LONG) || (s == ST_SHORT);
  endfunction

  function automatic pm_out_t decode_state(pm_state_e s);
    pm_out_t o;
    o = '{main_on: 1'b0, sub_on: 1'b1, cpu_on: 1'b0, cpu_fast: 1'b0, mode: MODE_IDLE};
    case (s)
      ST_GREEN:  o = '{1'b0, 1'b1, 1'b1, 1'b0, MODE_GREEN};
      ST_SWITCH: o = '{1'b1, 1'b1, 1'b1, 1'b0, MODE_GREEN};
      ST_NORMAL: o = '{1'b1, 1'b1, 1'b1, 1'b1, MODE_NORMAL};
      ST_IDLE:   o = '{1'b0, 1'b1, 1'b0, 1'b0, MODE_IDLE};
      ST_SLEEP:  o = '{1'b0, 1'b0, 1'b0, 1'b0, MODE_SLEEP};
      ST_SETUP:  o = '{1'b0, 1'b1, 1'b0, 1'b0, MODE_SLEEP};
      ST_LONG:   o = '{1'b0, 1'b1, 1'b0, 1'b0, MODE_SLEEP};
      ST_SHORT:  o = '{1'b0, 1'b1, 1'b0, 1'b0, MODE_IDLE};
      default:   o = '{1'b0, 1'b1, 1'b1, 1'b0, MODE_GREEN};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pmc_tick_counter.sv
module pmc_tick_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  assign last = tick && pmc_pkg::last_tick(32'(cnt_q), 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmc_state_seq.sv
module pmc_state_seq
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      boot_fast,
  input  logic      sleep_req,
  input  logic      idle_sel,
  input  logic      clk_fast_sel,
  input  logic      wake_evt,
  input  logic      sub_ready,
  input  logic      main_stable,
  input  logic      long_done,
  input  logic      short_done,
  output pm_state_e state_q,
  output logic      state_moves
);
  pm_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_GREEN: begin
        if (sleep_req)         state_d = halt_target(idle_sel);
        else if (clk_fast_sel) state_d = ST_SWITCH;
      end
      ST_SWITCH: begin
        if (sleep_req)          state_d = halt_target(idle_sel);
        else if (!clk_fast_sel) state_d = ST_GREEN;
        else if (main_stable)   state_d = ST_NORMAL;
      end
      ST_NORMAL: begin
        if (sleep_req)          state_d = halt_target(idle_sel);
        else if (!clk_fast_sel) state_d = ST_GREEN;
      end
      ST_IDLE:  if (wake_evt)   state_d = ST_SHORT;
      ST_SLEEP: if (wake_evt)   state_d = ST_SETUP;
      ST_SETUP: if (sub_ready)  state_d = ST_LONG;
      ST_LONG:  if (long_done)  state_d = ST_SHORT;
      ST_SHORT: if (short_done) state_d = ST_GREEN;
      default:                  state_d = ST_GREEN;
    endcase
  end

  assign state_moves = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= boot_fast ? ST_NORMAL : ST_GREEN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pmc_out_map.sv
module pmc_out_map
  import pmc_pkg::*;
(
  input  pm_state_e state,
  output logic      main_osc_en,
  output logic      sub_osc_en,
  output logic      cpu_clk_en,
  output logic      cpu_clk_main,
  output logic [1:0] mode_code
);
  pm_out_t o;

  always_comb o = decode_state(state);

  assign main_osc_en  = o.main_on;
  assign sub_osc_en   = o.sub_on;
  assign cpu_clk_en   = o.cpu_on;
  assign cpu_clk_main = o.cpu_fast;
  assign mode_code    = o.mode;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SHORT_TICKS = 16,
  parameter int LONG_TICKS  = 590
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_fast,
  input  logic       sleep_req,
  input  logic       idle_sel,
  input  logic       clk_fast_sel,
  input  logic       wake_evt,
  input  logic       sub_tick,
  input  logic       sub_ready,
  input  logic       main_stable,
  output logic       main_osc_en,
  output logic       sub_osc_en,
  output logic       cpu_clk_en,
  output logic       cpu_clk_main,
  output logic [1:0] mode_code
);
  localparam int CW = cnt_width(SHORT_TICKS, LONG_TICKS);
  localparam logic [CW-1:0] SHORT_L = CW'(SHORT_TICKS);
  localparam logic [CW-1:0] LONG_L  = CW'(LONG_TICKS);

  pm_state_e     state;
  logic          state_moves;
  logic          count_tick;
  logic [CW-1:0] delay_limit;
  logic          delay_last;
  // named internal events
  logic          long_done;
  logic          short_done;

  assign count_tick  = sub_tick && is_counting(state);
  assign delay_limit = (state == ST_LONG) ? LONG_L : SHORT_L;
  assign long_done   = delay_last && (state == ST_LONG);
  assign short_done  = delay_last && (state == ST_SHORT);

  pmc_state_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_fast   (boot_fast),
    .sleep_req   (sleep_req),
    .idle_sel    (idle_sel),
    .clk_fast_sel(clk_fast_sel),
    .wake_evt    (wake_evt),
    .sub_ready   (sub_ready),
    .main_stable (main_stable),
    .long_done   (long_done),
    .short_done  (short_done),
    .state_q     (state),
    .state_moves (state_moves)
  );

  pmc_tick_counter #(.CW(CW)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(state_moves),
    .tick (count_tick),
    .limit(delay_limit),
    .last (delay_last)
  );

  pmc_out_map u_map (
    .state       (state),
    .main_osc_en (main_osc_en),
    .sub_osc_en  (sub_osc_en),
    .cpu_clk_en  (cpu_clk_en),
    .cpu_clk_main(cpu_clk_main),
    .mode_code   (mode_code)
  );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       idle_sel,
  input logic       clk_fast_sel,
  input logic       wake_evt,
  input logic       main_stable,
  input logic       main_osc_en,
  input logic       sub_osc_en,
  input logic       cpu_clk_en,
  input logic       cpu_clk_main,
  input logic [1:0] mode_code,
  input logic       long_done,
  input logic       short_done
);
  // R2
  fast_needs_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_main |-> (main_osc_en && cpu_clk_en));

  // R2
  sub_off_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_osc_en |-> (!main_osc_en && !cpu_clk_en && mode_code == MODE_SLEEP));

  // R3
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_req && idle_sel) |=> (mode_code == MODE_IDLE && !cpu_clk_en));

  // R3
  halt_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_req && !idle_sel) |=> (!sub_osc_en && !cpu_clk_en));

  // R4
  wait_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_osc_en && !cpu_clk_main && !main_stable && clk_fast_sel && !sleep_req)
      |=> !cpu_clk_main);

  // R5
  slow_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_osc_en && !clk_fast_sel && !sleep_req) |=> (mode_code == MODE_GREEN && !main_osc_en));

  // R6
  wake_only_by_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> ($past(short_done) && mode_code == MODE_GREEN));

  // R7
  sleep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_osc_en && !wake_evt) |=> !sub_osc_en);

  // R7
  long_to_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_done |=> (mode_code == MODE_IDLE && !cpu_clk_en));

  // R8
  halted_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !short_done) |=> !cpu_clk_en);
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_req   (sleep_req),
  .idle_sel    (idle_sel),
  .clk_fast_sel(clk_fast_sel),
  .wake_evt    (wake_evt),
  .main_stable (main_stable),
  .main_osc_en (main_osc_en),
  .sub_osc_en  (sub_osc_en),
  .cpu_clk_en  (cpu_clk_en),
  .cpu_clk_main(cpu_clk_main),
  .mode_code   (mode_code),
  .long_done   (long_done),
  .short_done  (short_done)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int SHORT_T = 16;
  localparam int LONG_T  = 20;

  // {main_osc_en, sub_osc_en, cpu_clk_en, cpu_clk_main, mode_code}
  localparam logic [5:0] P_GREEN  = 6'b011000;
  localparam logic [5:0] P_NORMAL = 6'b111101;
  localparam logic [5:0] P_IDLE   = 6'b010010;
  localparam logic [5:0] P_SLEEP  = 6'b000011;
  localparam logic [5:0] P_SWITCH = 6'b111000;
  localparam logic [5:0] P_WAKES  = 6'b010011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_fast = 1'b0, sleep_req = 1'b0, idle_sel = 1'b0, clk_fast_sel = 1'b0;
  logic wake_evt = 1'b0, sub_tick = 1'b0, sub_ready = 1'b0, main_stable = 1'b0;
  logic main_osc_en, sub_osc_en, cpu_clk_en, cpu_clk_main;
  logic [1:0] mode_code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.SHORT_TICKS(SHORT_T), .LONG_TICKS(LONG_T)) uut (
    .clk(clk), .rst_n(rst_n), .boot_fast(boot_fast), .sleep_req(sleep_req),
    .idle_sel(idle_sel), .clk_fast_sel(clk_fast_sel), .wake_evt(wake_evt),
    .sub_tick(sub_tick), .sub_ready(sub_ready), .main_stable(main_stable),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .cpu_clk_en(cpu_clk_en),
    .cpu_clk_main(cpu_clk_main), .mode_code(mode_code)
  );

  function automatic logic [5:0] obs();
    return {main_osc_en, sub_osc_en, cpu_clk_en, cpu_clk_main, mode_code};
  endfunction

  task automatic chk(string req, logic [5:0] exp);
    n_chk++;
    if (obs() !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b, expected %b at %0t", req, obs(), exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      sub_tick = 1'b1; step();
      sub_tick = 1'b0; step();
    end
  endtask

  task automatic do_reset(logic b);
    rst_n = 1'b0; boot_fast = b;
    sleep_req = 0; idle_sel = 0; clk_fast_sel = b; wake_evt = 0;
    sub_tick = 0; sub_ready = 0; main_stable = 0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  // R1 R2
  task automatic t_reset();
    do_reset(1'b0); chk("R1 boot green", P_GREEN);
    step();         chk("R2 green held", P_GREEN);
    do_reset(1'b1); chk("R1 boot normal", P_NORMAL);
  endtask

  // R4 R5
  task automatic t_speed();
    do_reset(1'b0);
    clk_fast_sel = 1'b1; step(); chk("R4 main osc on, cpu on sub", P_SWITCH);
    repeat (4) step();   chk("R4 waits for main stable", P_SWITCH);
    main_stable = 1'b1; step(); chk("R4 normal after stable", P_NORMAL);
    clk_fast_sel = 1'b0; step(); chk("R5 normal to green", P_GREEN);
    main_stable = 1'b0;
    clk_fast_sel = 1'b1; step(); chk("R4 second request", P_SWITCH);
    clk_fast_sel = 1'b0; step(); chk("R5 abort pending switch", P_GREEN);
  endtask

  // R9 R10
  task automatic t_running_ignores();
    do_reset(1'b0);
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
    chk("R9 wake in green ignored", P_GREEN);
    ticks(SHORT_T + 2); chk("R9 ticks in green ignored", P_GREEN);
    sleep_req = 1'b1; idle_sel = 1'b1; clk_fast_sel = 1'b1; step();
    sleep_req = 1'b0; clk_fast_sel = 1'b0;
    chk("R10 sleep beats fast select", P_IDLE);
  endtask

  // R3 R6 R8 R9
  task automatic t_idle_wake();
    do_reset(1'b1);
    sleep_req = 1'b1; idle_sel = 1'b1; step(); sleep_req = 1'b0;
    chk("R3 normal to idle", P_IDLE);
    ticks(SHORT_T + 4); chk("R9 ticks without wake ignored", P_IDLE);
    clk_fast_sel = 1'b0;
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
    chk("R6 wake starts short delay", P_IDLE);
    ticks(8);
    sleep_req = 1'b1; idle_sel = 1'b0; clk_fast_sel = 1'b1; step();
    sleep_req = 1'b0; clk_fast_sel = 1'b0;
    chk("R8 sleep and fast select ignored in delay", P_IDLE);
    ticks(SHORT_T - 9); chk("R6 one tick short", P_IDLE);
    ticks(1);           chk("R6 green on last tick", P_GREEN);
  endtask

  // R3 R7 R8
  task automatic t_sleep_wake();
    do_reset(1'b0);
    sleep_req = 1'b1; idle_sel = 1'b0; step(); sleep_req = 1'b0;
    chk("R3 green to sleep", P_SLEEP);
    ticks(3); chk("R9 ticks in sleep ignored", P_SLEEP);
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
    chk("R7 sub osc restarts", P_WAKES);
    ticks(5); chk("R7 no count before sub ready", P_WAKES);
    sub_ready = 1'b1; step(); chk("R7 long delay started", P_WAKES);
    ticks(LONG_T - 1); chk("R7 long delay one short", P_WAKES);
    ticks(1);          chk("R7 long delay done", P_IDLE);
    ticks(SHORT_T - 1); chk("R8 no carry into short delay", P_IDLE);
    ticks(1);           chk("R7 green after short delay", P_GREEN);
  endtask

  // R3 R5
  task automatic t_halt_from_switch();
    do_reset(1'b0);
    clk_fast_sel = 1'b1; step(); chk("R4 pending switch", P_SWITCH);
    sleep_req = 1'b1; idle_sel = 1'b0; step(); sleep_req = 1'b0;
    chk("R3 sleep during pending switch", P_SLEEP);
  endtask

  initial begin
    step();
    t_reset();
    t_speed();
    t_running_ignores();
    t_idle_wake();
    t_sleep_wake();
    t_halt_from_switch();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung, expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule